// File: doc/BRIEF.md
# Capture/Waveform Timer Channel

This block is a single timer channel built around one free-running up-counter. Software sets it up through a small register port. The counter advances on every cycle in which the count-enable input is high, but only while the channel has been started. Three things can force the counter back to zero: a trigger bit written to the control register, a one-cycle pulse on the external sync input, or, if that option is enabled, a match against compare register C.

A mode bit picks one of two uses for the same counter and the same A/B/C registers:

- **Capture mode.** A single input signal is synchronised and watched for edges. On the edges selected by software, registers A and B take a snapshot of the counter.
- **Waveform mode.** Compare matches against A, B and C drive two output waveforms.

Events are recorded in a status register that clears when read. An enable mask then folds the flagged events into one interrupt line.

The register port has a single-cycle access and never stalls, so it carries no valid/ready handshake and has no back-pressure.

Register offsets: control 0x00, mode 0x04, counter 0x10, A 0x14, B 0x18, C 0x1C, status 0x20, interrupt enable 0x24.

Top module: `capwave_timer`

## Requirements
- R1: After reset, every register reads zero, the channel is stopped, and both waveform outputs and `irq_o` are low.
- R2: While the channel runs and `cnt_en` is high, the counter rises by one per clock; otherwise it holds. Writing the control register starts the channel with bit 0 and stops it with bit 1, and the stop bit wins. Control bit 0 reads back the run state.
- R3: Writing the control register with bit 2 set, or pulsing `ext_sync`, puts the counter at zero on the next clock, whatever the count enable is doing.
- R4: When the counter equals C on an advancing clock, status bit 3 is set. If mode bit 1 is also set, the counter goes to zero instead of incrementing.
- R5: Advancing from the all-ones value wraps the counter to zero and sets status bit 0.
- R6: In capture mode (mode bit 0 = 0), the input passes through a synchroniser. A is then loaded with the counter on the edges chosen by mode bits [5:4] (00 none, 01 rising, 10 falling, 11 both), and each load sets status bit 1.
- R7: In capture mode, B is loaded the same way on the edges chosen by mode bits [7:6], and each load sets status bit 2.
- R8: Bus writes to A and B are ignored in capture mode. C is writable in both modes.
- R9: In waveform mode (mode bit 0 = 1), an A match drives `wave_a_o` high and a C match drives it low, with C winning when both occur. A B match toggles `wave_b_o` and a C match drives it low. A and B matches set status bits 1 and 2.
- R10: One clock after capture mode is in force, both waveform outputs are low.
- R11: A status read returns the flags and clears them.
- R12: `irq_o` is high exactly when some status bit is set whose interrupt-enable bit (same position) is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable, one advance per high cycle |
| ext_sync | input | 1 | Synchronous counter clear pulse |
| sig_in | input | 1 | Asynchronous capture input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status when reading it) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid in the strobe cycle |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with `CNT_W` = 8 and `SYNC_STAGES` = 2. With an 8-bit counter, the wrap from all-ones to zero and its overflow flag take only 256 count-enable cycles. The compare, capture and reset-on-C cases fit inside a single short counter period. The count enable is held low around every capture, so the value snapshotted into A or B is known exactly despite the synchroniser latency.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] A_CNT  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CMPA = 8'h14;
  localparam logic [ADDR_W-1:0] A_CMPB = 8'h18;
  localparam logic [ADDR_W-1:0] A_CMPC = 8'h1C;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h24;

  // control register bits
  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_TRIG  = 2;

  // mode register bits
  localparam int MD_WAVE = 0;
  localparam int MD_CRST = 1;
  localparam int MD_EDA  = 4;
  localparam int MD_EDB  = 6;

  // status bits
  localparam int ST_W   = 4;
  localparam int ST_OVF = 0;
  localparam int ST_A   = 1;
  localparam int ST_B   = 2;
  localparam int ST_C   = 3;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync
  import tc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  input  edge_sel_e sel_a,
  input  edge_sel_e sel_b,
  output logic      hit_a,
  output logic      hit_b
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  function automatic logic pick(edge_sel_e s, logic r, logic f);
    case (s)
      EDGE_RISE: pick = r;
      EDGE_FALL: pick = f;
      EDGE_BOTH: pick = r | f;
      default:   pick = 1'b0;
    endcase
  endfunction

  assign hit_a = pick(sel_a, rise, fall);
  assign hit_b = pick(sel_b, rise, fall);
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic             c_rst_en,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  output logic [CNT_W-1:0] cnt,
  output logic             m_a,
  output logic             m_b,
  output logic             m_c,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic adv;
  logic c_restart;

  assign adv       = tick & run;
  assign m_a       = adv && (cnt == cmp_a);
  assign m_b       = adv && (cnt == cmp_b);
  assign m_c       = adv && (cnt == cmp_c);
  assign c_restart = c_rst_en & m_c;
  assign wrap      = adv && !clr && !c_restart && (cnt == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (c_restart) cnt <= '0;
    else if (adv)       cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/tc_wavegen.sv
module tc_wavegen (
  input  logic clk,
  input  logic rst_n,
  input  logic wave_en,
  input  logic m_a,
  input  logic m_b,
  input  logic m_c,
  output logic wave_a,
  output logic wave_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_a <= 1'b0;
      wave_b <= 1'b0;
    end else if (!wave_en) begin
      wave_a <= 1'b0;
      wave_b <= 1'b0;
    end else begin
      if (m_c)      wave_a <= 1'b0;
      else if (m_a) wave_a <= 1'b1;
      if (m_c)      wave_b <= 1'b0;
      else if (m_b) wave_b <= ~wave_b;
    end
  end
endmodule

// File: rtl/capwave_timer.sv
module capwave_timer
  import tc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              ext_sync,
  input  logic              sig_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              wave_a_o,
  output logic              wave_b_o,
  output logic              irq_o
);
  logic             run_q, wave_q, crst_q;
  edge_sel_e        eda_q, edb_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cmp_c_q;
  logic [ST_W-1:0]  stat_q, ie_q, stat_set;
  logic [CNT_W-1:0] cnt_q;
  logic             m_a, m_b, m_c, wrap;
  logic             hit_a, hit_b, cap_a, cap_b;
  logic             swtrg, clr;
  logic             wr_ctrl, wr_mode, wr_a, wr_b, wr_c, wr_ie, rd_stat;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_mode = bus_wr && (bus_addr == A_MODE);
  assign wr_a    = bus_wr && (bus_addr == A_CMPA);
  assign wr_b    = bus_wr && (bus_addr == A_CMPB);
  assign wr_c    = bus_wr && (bus_addr == A_CMPC);
  assign wr_ie   = bus_wr && (bus_addr == A_IEN);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  assign swtrg = wr_ctrl & bus_wdata[CTL_TRIG];
  assign clr   = swtrg | ext_sync;

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sig_in),
    .sel_a (eda_q),
    .sel_b (edb_q),
    .hit_a (hit_a),
    .hit_b (hit_b)
  );

  tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_en),
    .run      (run_q),
    .clr      (clr),
    .c_rst_en (crst_q),
    .cmp_a    (cmp_a_q),
    .cmp_b    (cmp_b_q),
    .cmp_c    (cmp_c_q),
    .cnt      (cnt_q),
    .m_a      (m_a),
    .m_b      (m_b),
    .m_c      (m_c),
    .wrap     (wrap)
  );

  tc_wavegen u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .wave_en (wave_q),
    .m_a     (m_a),
    .m_b     (m_b),
    .m_c     (m_c),
    .wave_a  (wave_a_o),
    .wave_b  (wave_b_o)
  );

  assign cap_a = hit_a & ~wave_q;
  assign cap_b = hit_b & ~wave_q;

  // control and mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wave_q <= 1'b0;
      crst_q <= 1'b0;
      eda_q  <= EDGE_NONE;
      edb_q  <= EDGE_NONE;
      ie_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        if (bus_wdata[CTL_STOP])       run_q <= 1'b0;
        else if (bus_wdata[CTL_START]) run_q <= 1'b1;
      end
      if (wr_mode) begin
        wave_q <= bus_wdata[MD_WAVE];
        crst_q <= bus_wdata[MD_CRST];
        eda_q  <= edge_sel_e'(bus_wdata[MD_EDA+1:MD_EDA]);
        edb_q  <= edge_sel_e'(bus_wdata[MD_EDB+1:MD_EDB]);
      end
      if (wr_ie) ie_q <= bus_wdata[ST_W-1:0];
    end
  end

  // compare/capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      cmp_c_q <= '0;
    end else begin
      if (cap_a)               cmp_a_q <= cnt_q;
      else if (wr_a && wave_q) cmp_a_q <= bus_wdata;
      if (cap_b)               cmp_b_q <= cnt_q;
      else if (wr_b && wave_q) cmp_b_q <= bus_wdata;
      if (wr_c)                cmp_c_q <= bus_wdata;
    end
  end

  // event flags
  always_comb begin
    stat_set         = '0;
    stat_set[ST_OVF] = wrap;
    stat_set[ST_A]   = wave_q ? m_a : cap_a;
    stat_set[ST_B]   = wave_q ? m_b : cap_b;
    stat_set[ST_C]   = m_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (rd_stat ? '0 : stat_q) | stat_set;
  end

  assign irq_o = |(stat_q & ie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = CNT_W'(run_q);
      A_MODE:  bus_rdata = CNT_W'({edb_q, eda_q, 2'b00, crst_q, wave_q});
      A_CNT:   bus_rdata = cnt_q;
      A_CMPA:  bus_rdata = cmp_a_q;
      A_CMPB:  bus_rdata = cmp_b_q;
      A_CMPC:  bus_rdata = cmp_c_q;
      A_STAT:  bus_rdata = CNT_W'(stat_q);
      A_IEN:   bus_rdata = CNT_W'(ie_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tc_chk.sv
module tc_chk
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              ext_sync,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              trig_bit,
  input logic              run_q,
  input logic              crst_q,
  input logic              wave_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_c_q,
  input logic [ST_W-1:0]   ie_q,
  input logic              wave_a_o,
  input logic              wave_b_o,
  input logic              irq_o
);
  logic trig, adv, c_hit;
  assign trig  = bus_wr && (bus_addr == A_CTRL) && trig_bit;
  assign adv   = cnt_en && run_q;
  assign c_hit = crst_q && (cnt_q == cmp_c_q);

  assert_sync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |=> (cnt_q == '0));

  assert_trig_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sync && !trig && !adv) |=> $stable(cnt_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ext_sync && !trig && !c_hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_crestart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && c_hit) |=> (cnt_q == '0));

  assert_cap_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_q |=> (!wave_a_o && !wave_b_o));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq_o);
endmodule

bind capwave_timer tc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .ext_sync (ext_sync),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .trig_bit (bus_wdata[tc_pkg::CTL_TRIG]),
  .run_q    (run_q),
  .crst_q   (crst_q),
  .wave_q   (wave_q),
  .cnt_q    (cnt_q),
  .cmp_c_q  (cmp_c_q),
  .ie_q     (ie_q),
  .wave_a_o (wave_a_o),
  .wave_b_o (wave_b_o),
  .irq_o    (irq_o)
);

// File: tb/capwave_timer_tb_top.sv
module capwave_timer_tb_top;
  import tc_pkg::*;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, ext_sync = 1'b0, sig_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic wave_a_o, wave_b_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  event         mon_ev;

  always #4 clk = ~clk;

  capwave_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_sync(ext_sync),
    .sig_in(sig_in), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wave_a_o(wave_a_o), .wave_b_o(wave_b_o), .irq_o(irq_o)
  );

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read 0x%0h expected 0x%0h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [W-1:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->mon_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic sig(input logic v);
    @(negedge clk);
    sig_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(wave_a_o, 1'b0, "R1 wave_a");
    chk(wave_b_o, 1'b0, "R1 wave_b");
    chk(irq_o, 1'b0, "R1 irq");
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rd(A_MODE, 8'h00, "R1 mode");
    rd(A_CNT,  8'h00, "R1 cnt");
    rd(A_CMPA, 8'h00, "R1 A");
    rd(A_CMPB, 8'h00, "R1 B");
    rd(A_CMPC, 8'h00, "R1 C");
    rd(A_STAT, 8'h00, "R1 status");
    rd(A_IEN,  8'h00, "R1 ie");

    // R2 counting, start/stop
    tick(5);
    rd(A_CNT, 8'd0, "R2 stopped holds");
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, 8'h01, "R2 run bit");
    tick(10);
    rd(A_CNT, 8'd10, "R2 ten ticks");
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, 8'h00, "R2 stop wins");
    tick(5);
    rd(A_CNT, 8'd10, "R2 hold when stopped");
    wr(A_CTRL, 8'h01);

    // R3 clears
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    rd(A_CNT, 8'd0, "R3 sync clear");
    tick(7);
    rd(A_CNT, 8'd7, "R3 count after sync");
    wr(A_CTRL, 8'h04);
    rd(A_CNT, 8'd0, "R3 software trigger");
    tick(3);
    @(negedge clk); cnt_en = 1'b1; ext_sync = 1'b1;
    @(negedge clk); cnt_en = 1'b0; ext_sync = 1'b0;
    rd(A_CNT, 8'd0, "R3 sync beats tick");

    // R6/R7 capture
    wr(A_CMPC, 8'd250);
    rd(A_STAT, 8'h08, "R4 C flag from earlier passes");
    wr(A_MODE, 8'h10);
    wr(A_CTRL, 8'h04);
    tick(20);
    sig(1'b1);
    rd(A_CMPA, 8'd20, "R6 rising capture");
    rd(A_CMPB, 8'd0,  "R7 B untouched with none");
    rd(A_STAT, 8'h02, "R6 A flag");
    rd(A_STAT, 8'h00, "R11 status cleared by read");
    tick(5);
    sig(1'b0);
    rd(A_CMPA, 8'd20, "R6 falling ignored on rise select");
    wr(A_MODE, 8'h60);
    sig(1'b1);
    rd(A_CMPB, 8'd25, "R7 rising capture B");
    rd(A_CMPA, 8'd20, "R6 A ignores rise on fall select");
    tick(5);
    sig(1'b0);
    rd(A_CMPA, 8'd30, "R6 falling capture A");
    rd(A_STAT, 8'h06, "R7 A and B flags");
    wr(A_MODE, 8'hF0);
    tick(2);
    sig(1'b1);
    rd(A_CMPA, 8'd32, "R6 both-edge capture A");
    rd(A_CMPB, 8'd32, "R7 both-edge capture B");
    rd(A_STAT, 8'h06, "R11 flags then clear");
    wr(A_MODE, 8'h00);
    sig(1'b0);
    tick(1);
    sig(1'b1);
    rd(A_CMPA, 8'd32, "R6 none select");
    rd(A_CMPB, 8'd32, "R7 none select");
    rd(A_STAT, 8'h00, "R6 no flag with none");

    // R8 bus writes in capture mode
    wr(A_CMPA, 8'h55);
    wr(A_CMPB, 8'h66);
    rd(A_CMPA, 8'd32, "R8 A write ignored");
    rd(A_CMPB, 8'd32, "R8 B write ignored");
    wr(A_CMPC, 8'h77);
    rd(A_CMPC, 8'h77, "R8 C writable");

    // R12 interrupt
    wr(A_IEN, 8'h02);
    wr(A_MODE, 8'h10);
    sig(1'b0);
    sig(1'b1);
    rd(A_CMPA, 8'd33, "R6 capture for irq");
    chk(irq_o, 1'b1, "R12 enabled flag raises irq");
    wr(A_IEN, 8'h04);
    chk(irq_o, 1'b0, "R12 masked flag");
    wr(A_IEN, 8'h02);
    chk(irq_o, 1'b1, "R12 re-enabled");
    rd(A_STAT, 8'h02, "R11 status with irq");
    chk(irq_o, 1'b0, "R12 irq drops after read");
    wr(A_IEN, 8'h00);

    // R4 reset on C
    wr(A_MODE, 8'h02);
    wr(A_CMPC, 8'd5);
    wr(A_CTRL, 8'h04);
    rd(A_STAT, 8'h00, "R4 clean status");
    tick(6);
    tick(2);
    rd(A_CNT, 8'd2, "R4 restart at C");
    rd(A_STAT, 8'h08, "R4 C flag");
    wr(A_MODE, 8'h00);
    wr(A_CTRL, 8'h04);
    tick(7);
    rd(A_CNT, 8'd7, "R4 no restart when disabled");
    rd(A_STAT, 8'h08, "R4 C flag without restart");

    // R5 wrap
    wr(A_CMPC, 8'd200);
    wr(A_CTRL, 8'h04);
    tick(255);
    rd(A_CNT, 8'd255, "R5 at all-ones");
    rd(A_STAT, 8'h08, "R5 no overflow yet");
    tick(1);
    rd(A_CNT, 8'd0, "R5 wrapped");
    rd(A_STAT, 8'h01, "R5 overflow flag");

    // R9 waveform
    wr(A_MODE, 8'h03);
    wr(A_CMPA, 8'd3);
    wr(A_CMPB, 8'd5);
    wr(A_CMPC, 8'd8);
    wr(A_CTRL, 8'h04);
    rd(A_STAT, 8'h00, "R9 clean status");
    chk(wave_a_o, 1'b0, "R9 a start low");
    chk(wave_b_o, 1'b0, "R9 b start low");
    tick(4);
    chk(wave_a_o, 1'b1, "R9 A match sets");
    chk(wave_b_o, 1'b0, "R9 b before B match");
    tick(2);
    chk(wave_a_o, 1'b1, "R9 a holds");
    chk(wave_b_o, 1'b1, "R9 B match toggles");
    tick(3);
    chk(wave_a_o, 1'b0, "R9 C clears a");
    chk(wave_b_o, 1'b0, "R9 C clears b");
    rd(A_CNT, 8'd0, "R4 wave period restart");
    rd(A_STAT, 8'h0E, "R9 match flags");
    tick(6);
    chk(wave_a_o, 1'b1, "R9 second period a");
    chk(wave_b_o, 1'b1, "R9 second period b");
    wr(A_CMPA, 8'd8);
    tick(3);
    chk(wave_a_o, 1'b0, "R9 C beats A");
    chk(wave_b_o, 1'b0, "R9 C clears b again");
    wr(A_CMPA, 8'd2);
    tick(6);
    chk(wave_a_o, 1'b1, "R9 a high before mode change");
    chk(wave_b_o, 1'b1, "R9 b high before mode change");

    // R10 capture mode silences outputs
    wr(A_MODE, 8'h00);
    @(negedge clk);
    chk(wave_a_o, 1'b0, "R10 a low in capture");
    chk(wave_b_o, 1'b0, "R10 b low in capture");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule